// File: doc/BRIEF.md
# Instruction Trace Interrupt Controller

This block sits beside a simple in-order execute stage and decides when a trace exception has to be taken. Two trace modes are supported. Single-step traces every completed instruction. Branch-trace traces only completed branches, whether or not they are taken. When a traced instruction completes, the block arms a pending flag. The next valid instruction is then pre-empted: the block redirects fetch to the trace vector and starts a two-cycle save sequence. The save sequence writes the return address first, then the saved status, and on that second cycle it clears the interrupt, privilege, relocation and trace enables in the machine state.

The saved status records whether the traced instruction behaved as a load or as a store. Cache-management operations are folded into one of those two classes. A pending trace beats an asynchronous interrupt that is requested in the same cycle. With no trace pending, the same save sequence serves the asynchronous interrupt, which uses its own vector.

Top module: `trace_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the pending flag and the save sequence, so `busy` is 0 and a valid instruction with both trace enables clear is not pre-empted.
- R2: With the single-step enable (`msrIn` bit 10) set, any completed instruction other than return-from-interrupt arms a trace.
- R3: With only the branch-trace enable (`msrIn` bit 9) set, a completed instruction of class BRANCH (code 3) arms a trace, and a completed instruction of any other class does not.
- R4: A completed return-from-interrupt instruction (class code 4) never arms a trace, even with both enables set.
- R5: An armed trace fires on the next valid instruction and pre-empts it. In that cycle `traceFire` and `redirect` are 1, `redirectAddr` equals `TRACE_VEC` (default 0xD00), `srr0We` is 1 and `srr0Data` is the address of the pre-empted instruction.
- R6: When a trace fires in the same cycle as an asynchronous request, the trace wins and `asyncTake` stays 0.
- R7: The saved status of a trace always has bit 30 set. Bit 28 is set for load-like classes: LOAD 1, ICBI 5, ICBT 6, DCBT 7, DCBST 8, DCBF 9. Bit 27 is set for store-like classes: STORE 2, DCBTST 10, DCBZ 11. For all other classes, neither bit 28 nor bit 27 is set. All other bits of the status are 0.
- R8: The cycle after a firing, `busy`, `srr1We` and `msrWe` are 1. `msrNext` equals `msrIn` with bits 15, 14, 10, 9, 5, 4 and 1 cleared, and the pending flag is cleared.
- R9: The pending flag is held over any number of cycles without a valid instruction. Arming happens only in cycles where an instruction completes.
- R10: With no trace pending, a valid instruction together with `asyncIrq` gives `asyncTake`, a redirect to `asyncVec` and an SRR0 write of the instruction address. On the next cycle the SRR1 write carries zero status.
- R11: While `busy` is 1, `instValid` is ignored: nothing fires and nothing arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instValid | input | 1 | An instruction is presented to execute this cycle |
| instClass | input | 4 | Class code of the presented instruction |
| instAddr | input | ADDR_W | Address of the presented instruction |
| msrIn | input | 64 | Current machine state (bit 0 = least significant) |
| asyncIrq | input | 1 | Asynchronous interrupt request |
| asyncVec | input | ADDR_W | Vector for the asynchronous interrupt |
| redirect | output | 1 | Pre-empt the presented instruction and redirect fetch |
| redirectAddr | output | ADDR_W | Redirect target |
| traceFire | output | 1 | The redirect is a trace interrupt |
| asyncTake | output | 1 | The redirect is the asynchronous interrupt |
| busy | output | 1 | Second save cycle; execute must hold |
| srr0We | output | 1 | Write the return address |
| srr0Data | output | ADDR_W | Return address |
| srr1We | output | 1 | Write the saved status |
| srr1Data | output | 64 | Saved status |
| msrWe | output | 1 | Write the machine state |
| msrNext | output | 64 | New machine state on entry |

## Verification
The bench walks every class code through single-step tracing and compares the status bits against the load-like and store-like lists. A design that put a cache operation in the wrong group would set the wrong bit, or none. Branch-trace is tried with a branch and with a load, and return-from-interrupt is tried with both enables set, because a wrongly gated arm would fire on a non-branch or after a return. Further cases cover a trace and an asynchronous request landing together, a pending flag held over idle cycles while the asynchronous request is high, and an instruction presented during `busy`. These catch a design that lets the asynchronous request win, drops or fires the pending flag early, or records the stalled instruction as completed.

// File: rtl/trace_pkg.sv
package trace_pkg;

  localparam int MSR_W  = 64;
  localparam int SRR1_W = 64;

  // machine-state bit positions, bit 0 = least significant
  localparam int MSR_EE_BIT = 15;
  localparam int MSR_PR_BIT = 14;
  localparam int MSR_SE_BIT = 10;
  localparam int MSR_BT_BIT = 9;
  localparam int MSR_IR_BIT = 5;
  localparam int MSR_DR_BIT = 4;
  localparam int MSR_RI_BIT = 1;

  // saved-status bit positions
  localparam int ST_TRACE_BIT = 30;
  localparam int ST_LOAD_BIT  = 28;
  localparam int ST_STORE_BIT = 27;

  typedef enum logic [3:0] {
    CLS_OTHER  = 4'd0,
    CLS_LOAD   = 4'd1,
    CLS_STORE  = 4'd2,
    CLS_BRANCH = 4'd3,
    CLS_RFI    = 4'd4,
    CLS_ICINV  = 4'd5,
    CLS_ICTCH  = 4'd6,
    CLS_DCTCH  = 4'd7,
    CLS_DCSTR  = 4'd8,
    CLS_DCFLS  = 4'd9,
    CLS_DCTST  = 4'd10,
    CLS_DCZERO = 4'd11
  } instClass_e;

  typedef struct packed {
    logic complete;
    logic fireTrace;
    logic fireAsync;
    logic writeSrr1;
  } ctrlStrobe_t;

  function automatic logic isLoadLike(input logic [3:0] c);
    case (c)
      CLS_LOAD, CLS_ICINV, CLS_ICTCH, CLS_DCTCH, CLS_DCSTR, CLS_DCFLS: isLoadLike = 1'b1;
      default: isLoadLike = 1'b0;
    endcase
  endfunction

  function automatic logic isStoreLike(input logic [3:0] c);
    case (c)
      CLS_STORE, CLS_DCTST, CLS_DCZERO: isStoreLike = 1'b1;
      default: isStoreLike = 1'b0;
    endcase
  endfunction

  function automatic logic [MSR_W-1:0] entryClearMask();
    logic [MSR_W-1:0] m;
    m = '0;
    m[MSR_EE_BIT] = 1'b1;
    m[MSR_PR_BIT] = 1'b1;
    m[MSR_SE_BIT] = 1'b1;
    m[MSR_BT_BIT] = 1'b1;
    m[MSR_IR_BIT] = 1'b1;
    m[MSR_DR_BIT] = 1'b1;
    m[MSR_RI_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             instValid,
  input  logic [3:0]       instClass,
  input  logic [MSR_W-1:0] msrIn,
  input  logic             asyncIrq,
  output ctrlStrobe_t      strobe,
  output logic             busy
);

  typedef enum logic {ST_RUN, ST_SAVE1} state_e;

  state_e stateQ;
  logic   pendingQ;
  logic   accept;
  logic   armHit;
  logic   isRfi;
  logic   isBranch;

  always_comb begin
    busy     = (stateQ == ST_SAVE1);
    accept   = instValid && !busy;
    isRfi    = (instClass == CLS_RFI);
    isBranch = (instClass == CLS_BRANCH);

    strobe.fireTrace = accept && pendingQ;
    strobe.fireAsync = accept && !pendingQ && asyncIrq;
    strobe.complete  = accept && !pendingQ && !asyncIrq;
    strobe.writeSrr1 = busy;

    armHit = strobe.complete && !isRfi &&
             (msrIn[MSR_SE_BIT] || (msrIn[MSR_BT_BIT] && isBranch));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pendingQ <= 1'b0;
      stateQ   <= ST_RUN;
    end else begin
      if (armHit) pendingQ <= 1'b1;
      else if (strobe.writeSrr1) pendingQ <= 1'b0;

      case (stateQ)
        ST_RUN:   if (strobe.fireTrace || strobe.fireAsync) stateQ <= ST_SAVE1;
        default:  stateQ <= ST_RUN;
      endcase
    end
  end

endmodule

// File: rtl/trace_dpath.sv
module trace_dpath
  import trace_pkg::*;
#(
  parameter int              ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] TRACE_VEC = 'hD00
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [3:0]        instClass,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [MSR_W-1:0]  msrIn,
  input  logic [ADDR_W-1:0] asyncVec,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic              srr0We,
  output logic [ADDR_W-1:0] srr0Data,
  output logic              srr1We,
  output logic [SRR1_W-1:0] srr1Data,
  output logic              msrWe,
  output logic [MSR_W-1:0]  msrNext
);

  localparam logic [MSR_W-1:0] CLEAR_MASK = entryClearMask();

  logic [3:0]        lastClassQ;
  logic [SRR1_W-1:0] srr1HoldQ;
  logic [SRR1_W-1:0] traceStatus;

  always_comb begin
    traceStatus = '0;
    traceStatus[ST_TRACE_BIT] = 1'b1;
    traceStatus[ST_LOAD_BIT]  = isLoadLike(lastClassQ);
    traceStatus[ST_STORE_BIT] = isStoreLike(lastClassQ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastClassQ <= CLS_OTHER;
      srr1HoldQ  <= '0;
    end else begin
      if (strobe.complete) lastClassQ <= instClass;
      if (strobe.fireTrace) srr1HoldQ <= traceStatus;
      else if (strobe.fireAsync) srr1HoldQ <= '0;
    end
  end

  always_comb begin
    redirect     = strobe.fireTrace || strobe.fireAsync;
    redirectAddr = strobe.fireTrace ? TRACE_VEC : asyncVec;
    srr0We       = redirect;
    srr0Data     = instAddr;
    srr1We       = strobe.writeSrr1;
    srr1Data     = srr1HoldQ;
    msrWe        = strobe.writeSrr1;
    msrNext      = msrIn & ~CLEAR_MASK;
  end

endmodule

// File: rtl/trace_irq_ctrl.sv
module trace_irq_ctrl
  import trace_pkg::*;
#(
  parameter int                ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] TRACE_VEC = 'hD00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [3:0]        instClass,
  input  logic [ADDR_W-1:0] instAddr,
  input  logic [63:0]       msrIn,
  input  logic              asyncIrq,
  input  logic [ADDR_W-1:0] asyncVec,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirectAddr,
  output logic              traceFire,
  output logic              asyncTake,
  output logic              busy,
  output logic              srr0We,
  output logic [ADDR_W-1:0] srr0Data,
  output logic              srr1We,
  output logic [63:0]       srr1Data,
  output logic              msrWe,
  output logic [63:0]       msrNext
);

  ctrlStrobe_t strobe;

  trace_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .instValid (instValid),
    .instClass (instClass),
    .msrIn     (msrIn),
    .asyncIrq  (asyncIrq),
    .strobe    (strobe),
    .busy      (busy)
  );

  trace_dpath #(.ADDR_W(ADDR_W), .TRACE_VEC(TRACE_VEC)) u_dpath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .instClass    (instClass),
    .instAddr     (instAddr),
    .msrIn        (msrIn),
    .asyncVec     (asyncVec),
    .redirect     (redirect),
    .redirectAddr (redirectAddr),
    .srr0We       (srr0We),
    .srr0Data     (srr0Data),
    .srr1We       (srr1We),
    .srr1Data     (srr1Data),
    .msrWe        (msrWe),
    .msrNext      (msrNext)
  );

  assign traceFire = strobe.fireTrace;
  assign asyncTake = strobe.fireAsync;

endmodule

// File: rtl/trace_irq_chk.sv
module trace_irq_chk #(
  parameter int                ADDR_W    = 64,
  parameter logic [ADDR_W-1:0] TRACE_VEC = 'hD00
) (
  input logic              clk,
  input logic              rst,
  input logic              instValid,
  input logic              redirect,
  input logic [ADDR_W-1:0] redirectAddr,
  input logic              traceFire,
  input logic              asyncTake,
  input logic              busy,
  input logic              srr0We,
  input logic              srr1We,
  input logic [63:0]       srr1Data,
  input logic              msrWe,
  input logic [63:0]       msrNext
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busy);

  assert_trace_vector_R5: assert property (@(posedge clk) disable iff (rst)
    traceFire |-> (redirect && srr0We && redirectAddr == TRACE_VEC));

  assert_trace_beats_async_R6: assert property (@(posedge clk) disable iff (rst)
    traceFire |-> !asyncTake);

  assert_status_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    srr1We |-> !(srr1Data[28] && srr1Data[27]));

  assert_save_follows_fire_R8: assert property (@(posedge clk) disable iff (rst)
    traceFire |=> (busy && srr1We && msrWe && srr1Data[30]));

  assert_enables_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    msrWe |-> (!msrNext[10] && !msrNext[9]));

  assert_fire_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    redirect |-> instValid);

  assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!redirect && !srr0We));

endmodule

bind trace_irq_ctrl trace_irq_chk #(.ADDR_W(ADDR_W), .TRACE_VEC(TRACE_VEC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .instValid    (instValid),
  .redirect     (redirect),
  .redirectAddr (redirectAddr),
  .traceFire    (traceFire),
  .asyncTake    (asyncTake),
  .busy         (busy),
  .srr0We       (srr0We),
  .srr1We       (srr1We),
  .srr1Data     (srr1Data),
  .msrWe        (msrWe),
  .msrNext      (msrNext)
);

// File: tb/sim_trace_irq_ctrl.sv
module sim_trace_irq_ctrl;

  localparam int AW = 64;
  localparam logic [63:0] SE_ON = 64'h400;
  localparam logic [63:0] BT_ON = 64'h200;
  localparam logic [63:0] CLR   = 64'h0000_0000_0000_C632;
  localparam logic [63:0] AVEC  = 64'h500;

  logic clk = 0;
  logic rst = 1;
  logic instValid = 0;
  logic [3:0] instClass = 0;
  logic [AW-1:0] instAddr = 0;
  logic [63:0] msrIn = 0;
  logic asyncIrq = 0;
  logic [AW-1:0] asyncVec = AVEC;
  logic redirect, traceFire, asyncTake, busy, srr0We, srr1We, msrWe;
  logic [AW-1:0] redirectAddr, srr0Data;
  logic [63:0] srr1Data, msrNext;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  trace_irq_ctrl u0 (
    .clk(clk), .rst(rst), .instValid(instValid), .instClass(instClass),
    .instAddr(instAddr), .msrIn(msrIn), .asyncIrq(asyncIrq), .asyncVec(asyncVec),
    .redirect(redirect), .redirectAddr(redirectAddr), .traceFire(traceFire),
    .asyncTake(asyncTake), .busy(busy), .srr0We(srr0We), .srr0Data(srr0Data),
    .srr1We(srr1We), .srr1Data(srr1Data), .msrWe(msrWe), .msrNext(msrNext)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one cycle's inputs after the edge, outputs settle by the falling edge
  task automatic cyc(input logic v, input logic [3:0] c, input logic [63:0] a,
                     input logic [63:0] m, input logic ai);
    @(posedge clk); #1;
    instValid = v; instClass = c; instAddr = a; msrIn = m; asyncIrq = ai;
    @(negedge clk);
  endtask

  function automatic logic [63:0] expStatus(input int c);
    logic [63:0] s;
    s = 64'h4000_0000;
    if (c == 1 || (c >= 5 && c <= 9)) s[28] = 1'b1;
    if (c == 2 || c == 10 || c == 11) s[27] = 1'b1;
    return s;
  endfunction

  task automatic doReset();
    rst = 1;
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    rst = 0;
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic testReset();
    check("R1", "busy after reset", busy, 0);
    cyc(1, 1, 64'h100, 0, 0);
    check("R1", "no redirect after reset", redirect, 0);
    cyc(1, 0, 64'h104, 0, 0);
    check("R1", "no fire untraced", traceFire, 0);
  endtask

  task automatic testSingleStep();
    for (int c = 0; c < 16; c++) begin
      if (c == 4) continue;
      cyc(1, c[3:0], 64'h2000, SE_ON, 0);
      check("R2", "armed inst not pre-empted", redirect, 0);
      cyc(1, 0, 64'h2004 + 64'(c), 0, 0);
      check("R2", "single-step fires", traceFire, 1);
      check("R5", "redirect", redirect, 1);
      check("R5", "vector", redirectAddr, 64'hD00);
      check("R5", "srr0We", srr0We, 1);
      check("R5", "srr0 addr", srr0Data, 64'h2004 + 64'(c));
      cyc(0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0);
      check("R8", "busy", busy, 1);
      check("R8", "srr1We", srr1We, 1);
      check("R7", "status bits", srr1Data, expStatus(c));
      check("R8", "msrWe", msrWe, 1);
      check("R8", "msr cleared", msrNext, ~CLR);
      cyc(1, 0, 64'h3000, 0, 0);
      check("R8", "pending cleared", redirect, 0);
    end
  endtask

  task automatic testBranchTrace();
    cyc(1, 3, 64'h40, BT_ON, 0);
    cyc(1, 0, 64'h80, 0, 0);
    check("R3", "branch trace fires", traceFire, 1);
    cyc(0, 0, 0, 0, 0);
    check("R3", "branch status", srr1Data, 64'h4000_0000);
    cyc(1, 1, 64'h44, BT_ON, 0);
    cyc(1, 0, 64'h48, 0, 0);
    check("R3", "non-branch not traced", redirect, 0);
  endtask

  task automatic testRfi();
    cyc(1, 4, 64'h60, SE_ON | BT_ON, 0);
    cyc(1, 0, 64'h64, 0, 0);
    check("R4", "return never arms", redirect, 0);
  endtask

  task automatic testPriority();
    cyc(1, 2, 64'h70, SE_ON, 0);
    cyc(1, 0, 64'h74, 0, 1);
    check("R6", "trace fires", traceFire, 1);
    check("R6", "async held off", asyncTake, 0);
    check("R6", "trace vector", redirectAddr, 64'hD00);
    cyc(0, 0, 0, 0, 1);
    check("R6", "store status kept", srr1Data, 64'h4800_0000);
  endtask

  task automatic testHold();
    cyc(1, 1, 64'h90, SE_ON, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, SE_ON, 1);
      check("R9", "idle no redirect", redirect, 0);
    end
    cyc(1, 0, 64'h94, 0, 1);
    check("R9", "held trace fires", traceFire, 1);
    cyc(0, 0, 0, 0, 0);
    check("R9", "load status", srr1Data, 64'h5000_0000);
  endtask

  task automatic testAsync();
    cyc(1, 1, 64'hA0, SE_ON, 1);
    check("R10", "async taken", asyncTake, 1);
    check("R10", "async vector", redirectAddr, AVEC);
    check("R10", "srr0 addr", srr0Data, 64'hA0);
    check("R10", "no trace", traceFire, 0);
    cyc(0, 0, 0, 0, 0);
    check("R10", "srr1We", srr1We, 1);
    check("R10", "zero status", srr1Data, 0);
    cyc(1, 0, 64'hA4, 0, 0);
    check("R10", "pre-empted inst did not arm", redirect, 0);
  endtask

  task automatic testBusyIgnore();
    cyc(1, 0, 64'hB0, SE_ON, 0);
    cyc(1, 0, 64'hB4, 0, 0);
    check("R11", "fire", traceFire, 1);
    cyc(1, 1, 64'hB8, SE_ON, 1);
    check("R11", "busy", busy, 1);
    check("R11", "no redirect while busy", redirect, 0);
    cyc(1, 0, 64'hBC, 0, 0);
    check("R11", "busy inst did not arm", redirect, 0);
  endtask

  initial begin
    doReset();
    testReset();
    testSingleStep();
    testBranchTrace();
    testRfi();
    testPriority();
    testHold();
    testAsync();
    testBusyIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule